// File: doc/BRIEF.md
# Signed Radix-4 Booth Multiplier with Height-Split Column Reduction

This block multiplies two signed two's-complement operands of the same parameterised width `N` and returns the full `2N`-bit product. The multiplier operand is recoded into radix-4 digits from overlapping three-bit windows. This yields `ceil(N/2)` partial-product rows, each selected from the multiplicand as 0, ±1 or ±2 times its value.

The bits of the partial-product rows are summed one weight column at a time. A column of two bits goes through a half adder and a column of three through a full adder. A taller column goes through a parallel counter, which emits the binary count of its ones at consecutive weights. Stages repeat until every column holds at most two bits. A plain ripple-carry adder then merges the two remaining rows.

A parameter selects whether the product leaves the block combinationally or through one output register. The block is meant as a multiply primitive inside filter and MAC datapaths.

Top module: `booth_wallace_mul`

## Requirements
- R1: `p_o` equals the two's-complement product of `a_i` and `b_i`, taken modulo 2^(2N), for every operand pair.
- R2: The most negative operand value -2^(N-1) is handled exactly. (-2^(N-1))·(-2^(N-1)) gives +2^(2N-2), and (-2^(N-1))·(-1) gives +2^(N-1).
- R3: Digit recoding uses windows {b[2j+1], b[2j], b[2j-1]}, with an implied 0 below bit 0. Window 111 and window 000 both select a zero row, so `b_i` = all ones yields `p_o` = -`a_i`.
- R4: For odd `N` the multiplier is sign-extended by one bit before recoding, and R1 holds (checked at N=5).
- R5: A negative digit forms its row as the bitwise inverse of the selected multiple, plus a 1 added at the row's lowest column. A -2 digit applied to -2^(N-1) therefore contributes exactly +2^N.
- R6: When either operand is zero, `p_o` is zero.
- R7: When both operands are nonzero, `p_o[2N-1]` equals `a_i[N-1]` XOR `b_i[N-1]`.
- R8: With `REG_OUT`=1 the product of the operands present at a rising clock edge appears on `p_o` after that edge and holds until the next one. With `REG_OUT`=0 it appears in the same cycle.
- R9: With `REG_OUT`=1, a low `rst_ni` clears `p_o` to zero at once, without waiting for a clock edge.
- R10: The same RTL is correct at `N` = 4, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | N | Signed multiplicand |
| b_i | input | N | Signed multiplier (Booth-recoded) |
| p_o | output | 2N | Signed product |

## Verification
The riskiest coincidence is a negative-digit correction bit and a sign-extension constant bit falling into the same column as the inverted sign bit of an adjacent row. That column then grows tall enough to need a counter in place of a full adder. Several conditions raise this coincidence at once: multiplier patterns made only of -1 and -2 digits, an all-ones multiplier, and a most-negative multiplicand. Every case is judged against the arithmetic product, and the sweep is exhaustive at N=4, 5 and 8. A second overlap sits in the registered variant, where an asynchronous reset pulse lands between clock edges while a nonzero product is held. Its output is checked before the next edge.

// File: rtl/booth_wallace_pkg.sv
package booth_wallace_pkg;

  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } bdigit_t;

  localparam int MAX_COLS = 128;

  function automatic int n_digits(int n);
    return (n + 1) / 2;
  endfunction

  // bits needed to hold a count of 0..h
  function automatic int cnt_bits(int h);
    int w;
    w = 0;
    while ((1 << w) <= h) w++;
    return w;
  endfunction

  // sign-extension constant: -sum_j 2^(n+2j) mod 2^(2n)
  function automatic logic [MAX_COLS-1:0] kvec(int n);
    logic [MAX_COLS-1:0] k;
    k = '0;
    for (int j = 0; j < n_digits(n); j++) k = k - (MAX_COLS'(1) << (n + 2 * j));
    return k;
  endfunction

  function automatic int h_init(int n, int c);
    logic [MAX_COLS-1:0] k;
    int h;
    k = kvec(n);
    h = 0;
    for (int j = 0; j < n_digits(n); j++)
      if (c >= 2 * j && c <= 2 * j + n) h++;
    if ((c % 2) == 0 && (c / 2) < n_digits(n)) h++;
    if (k[c]) h++;
    return h;
  endfunction

  // bits a column of height h sends k columns up
  function automatic int contrib(int h, int k);
    if (h <= 1) return (k == 0) ? h : 0;
    return (k < cnt_bits(h)) ? 1 : 0;
  endfunction

  // height of column c after s stages; c < 0 returns the stage maximum
  function automatic int h_at(int n, int s, int c);
    int h [MAX_COLS];
    int nh [MAX_COLS];
    int m;
    for (int t = 0; t < 2 * n; t++) h[t] = h_init(n, t);
    for (int st = 0; st < s; st++) begin
      for (int t = 0; t < 2 * n; t++) begin
        nh[t] = 0;
        for (int k = 0; k <= t; k++) nh[t] += contrib(h[t-k], k);
      end
      for (int t = 0; t < 2 * n; t++) h[t] = nh[t];
    end
    if (c >= 0) return h[c];
    m = 0;
    for (int t = 0; t < 2 * n; t++) if (h[t] > m) m = h[t];
    return m;
  endfunction

  // slot in column t (stage s+1) of the bit arriving from column t-k
  function automatic int h_off(int n, int s, int t, int k);
    int o;
    o = 0;
    for (int j = 0; j < k; j++)
      if (t - j >= 0) o += contrib(h_at(n, s, t - j), j);
    return o;
  endfunction

  function automatic int n_stages(int n);
    for (int s = 0; s < 16; s++)
      if (h_at(n, s, -1) <= 2) return s;
    return 16;
  endfunction

  function automatic int h_peak(int n);
    int m;
    m = 2;
    for (int s = 0; s <= n_stages(n); s++)
      if (h_at(n, s, -1) > m) m = h_at(n, s, -1);
    return m;
  endfunction

endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_wallace_pkg::*;
(
  input  logic [2:0] trip_i,
  output bdigit_t    dig_o
);
  assign dig_o.neg = trip_i[2];
  assign dig_o.one = trip_i[1] ^ trip_i[0];
  assign dig_o.two = (trip_i[2] & ~trip_i[1] & ~trip_i[0]) |
                     (~trip_i[2] & trip_i[1] & trip_i[0]);
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_wallace_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a_i,
  input  bdigit_t      dig_i,
  output logic [N:0]   row_o
);
  logic [N:0] mag;

  always_comb begin
    if (dig_i.one)      mag = {a_i[N-1], a_i};
    else if (dig_i.two) mag = {a_i, 1'b0};
    else                mag = '0;
    // one's complement; the +1 is injected as a separate column bit
    row_o = mag ^ {(N+1){dig_i.neg}};
  end
endmodule

// File: rtl/col_counter.sv
module col_counter #(
  parameter int unsigned M  = 3,
  parameter int unsigned OW = 2
) (
  input  logic [M-1:0]  bits_i,
  output logic [OW-1:0] cnt_o
);
  if (M == 2 && OW == 2) begin : g_ha
    assign cnt_o = {bits_i[1] & bits_i[0], bits_i[1] ^ bits_i[0]};
  end else if (M == 3 && OW == 2) begin : g_fa
    assign cnt_o = {(bits_i[0] & bits_i[1]) | (bits_i[2] & (bits_i[0] ^ bits_i[1])),
                    ^bits_i};
  end else begin : g_par
    // m:k parallel counter, truncated to OW bits at the top columns
    always_comb begin
      cnt_o = '0;
      for (int i = 0; i < int'(M); i++) cnt_o = cnt_o + OW'(bits_i[i]);
    end
  end
endmodule

// File: rtl/wallace_reduce.sv
module wallace_reduce
  import booth_wallace_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned P = n_digits(N),
  localparam int unsigned W = 2 * N
) (
  input  logic [P-1:0][N:0] pp_i,
  input  logic [P-1:0]      neg_i,
  output logic [W-1:0]      row0_o,
  output logic [W-1:0]      row1_o
);
  localparam int NSTG = n_stages(N);
  localparam int HMAX = h_peak(N);
  localparam logic [MAX_COLS-1:0] KALL = kvec(N);

  logic [W-1:0][HMAX-1:0]      lvl0;
  wire  [NSTG:0][W-1:0][HMAX-1:0] lvl;
  logic unused_lvl;

  always_comb begin
    int idx;
    lvl0 = '0;
    for (int c = 0; c < int'(W); c++) begin
      idx = 0;
      for (int j = 0; j < int'(P); j++) begin
        if (c >= 2 * j && c <= 2 * j + int'(N)) begin
          lvl0[c][idx] = (c == 2 * j + int'(N)) ? ~pp_i[j][N] : pp_i[j][c-2*j];
          idx++;
        end
      end
      if ((c % 2) == 0 && (c / 2) < int'(P)) begin
        lvl0[c][idx] = neg_i[c/2];
        idx++;
      end
      if (KALL[c]) lvl0[c][idx] = 1'b1;
    end
  end

  assign lvl[0] = lvl0;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    for (genvar c = 0; c < int'(W); c++) begin : g_col
      localparam int H  = h_at(N, s, c);
      localparam int HN = h_at(N, s + 1, c);
      localparam int CW = cnt_bits(H);
      localparam int OW = (CW < int'(W) - c) ? CW : int'(W) - c;
      if (H >= 2) begin : g_cnt
        logic [OW-1:0] cnt;
        col_counter #(.M(H), .OW(OW)) i_cnt (
          .bits_i(lvl[s][c][H-1:0]),
          .cnt_o (cnt)
        );
        for (genvar k = 0; k < OW; k++) begin : g_out
          localparam int OFS = h_off(N, s, c + k, k);
          assign lvl[s+1][c+k][OFS] = cnt[k];
        end
      end else if (H == 1) begin : g_pass
        assign lvl[s+1][c][0] = lvl[s][c][0];
      end
      for (genvar i = HN; i < HMAX; i++) begin : g_pad
        assign lvl[s+1][c][i] = 1'b0;
      end
    end
  end

  for (genvar c = 0; c < int'(W); c++) begin : g_rows
    assign row0_o[c] = lvl[NSTG][c][0];
    assign row1_o[c] = lvl[NSTG][c][1];
  end

  assign unused_lvl = ^lvl;
endmodule

// File: rtl/rca_adder.sv
module rca_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  logic [W-1:1] cy;

  for (genvar i = 0; i < int'(W); i++) begin : g_bit
    if (i == 0) begin : g_ha
      assign s_o[0] = x_i[0] ^ y_i[0];
      assign cy[1]  = x_i[0] & y_i[0];
    end else if (i == int'(W) - 1) begin : g_top
      assign s_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
    end else begin : g_fa
      assign s_o[i]  = x_i[i] ^ y_i[i] ^ cy[i];
      assign cy[i+1] = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
    end
  end
endmodule

// File: rtl/booth_wallace_mul.sv
module booth_wallace_mul
  import booth_wallace_pkg::*;
#(
  parameter int unsigned N       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);
  localparam int unsigned P  = n_digits(N);
  localparam int unsigned NE = 2 * P;
  localparam int unsigned W  = 2 * N;

  logic [NE:0]       b_ext;
  bdigit_t [P-1:0]   dig;
  logic [P-1:0][N:0] pp;
  logic [P-1:0]      neg;
  logic [W-1:0]      row0, row1, sum;

  // sign-extend to an even width, append the implied 0 below bit 0
  assign b_ext = {NE'($signed(b_i)), 1'b0};

  for (genvar j = 0; j < int'(P); j++) begin : g_dig
    booth_enc i_enc (
      .trip_i(b_ext[2*j+2:2*j]),
      .dig_o (dig[j])
    );
    booth_ppgen #(.N(N)) i_pp (
      .a_i  (a_i),
      .dig_i(dig[j]),
      .row_o(pp[j])
    );
    assign neg[j] = dig[j].neg;
  end

  wallace_reduce #(.N(N)) i_red (
    .pp_i  (pp),
    .neg_i (neg),
    .row0_o(row0),
    .row1_o(row1)
  );

  rca_adder #(.W(W)) i_rca (
    .x_i(row0),
    .y_i(row1),
    .s_o(sum)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= '0;
      else         p_q <= sum;
    end
    assign p_o = p_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign p_o = sum;
  end
endmodule

// File: rtl/booth_wallace_mul_chk.sv
module booth_wallace_mul_chk #(
  parameter int unsigned N       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [2*N-1:0] p_o
);
  logic [N-1:0]   a_q, b_q;
  logic           vld_q;
  logic [2*N-1:0] exp_p, neg_a;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q   <= '0;
        b_q   <= '0;
        vld_q <= 1'b0;
      end else begin
        a_q   <= a_i;
        b_q   <= b_i;
        vld_q <= 1'b1;
      end
    end

    p_reset_clear_r9: assert property (@(posedge clk_i) !rst_ni |-> p_o == '0);
  end else begin : g_comb
    assign a_q   = a_i;
    assign b_q   = b_i;
    assign vld_q = 1'b1;
  end

  assign exp_p = (2*N)'($signed(a_q)) * (2*N)'($signed(b_q));
  assign neg_a = -((2*N)'($signed(a_q)));

  p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> p_o == exp_p);

  p_all_ones_mult_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && (&b_q)) |-> p_o == neg_a);

  p_zero_operand_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && (a_q == '0 || b_q == '0)) |-> p_o == '0);

  p_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && a_q != '0 && b_q != '0) |-> p_o[2*N-1] == (a_q[N-1] ^ b_q[N-1]));
endmodule

bind booth_wallace_mul booth_wallace_mul_chk #(.N(N), .REG_OUT(REG_OUT)) i_booth_wallace_mul_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .a_i   (a_i),
  .b_i   (b_i),
  .p_o   (p_o)
);

// File: tb/test_booth_wallace_mul.sv
module test_booth_wallace_mul;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk, rst_ni;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;
  logic [4:0]  a5, b5;
  logic [9:0]  p5;
  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [15:0] a16, b16;
  logic [31:0] p16;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  booth_wallace_mul #(.N(4), .REG_OUT(1'b1)) i_booth_wallace_mul (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a4), .b_i(b4), .p_o(p4));
  booth_wallace_mul #(.N(5), .REG_OUT(1'b0)) i_booth_wallace_mul_n5 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a5), .b_i(b5), .p_o(p5));
  booth_wallace_mul #(.N(8), .REG_OUT(1'b0)) i_booth_wallace_mul_n8 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a8), .b_i(b8), .p_o(p8));
  booth_wallace_mul #(.N(16), .REG_OUT(1'b1)) i_booth_wallace_mul_n16 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a16), .b_i(b16), .p_o(p16));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // registered 16-bit instance: drive at negedge, result after one edge
  task automatic run16(string tag, int ia, int ib);
    a16 = 16'(ia);
    b16 = 16'(ib);
    @(negedge clk);
    check(tag, longint'($signed(p16)), longint'(ia) * longint'(ib));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    longint prev4;
    int corners [6];
    rst_ni = 1'b1;
    a4 = '0; b4 = '0; a5 = '0; b5 = '0; a8 = '0; b8 = '0; a16 = '0; b16 = '0;
    #1 rst_ni = 1'b0;
    a4 = 4'd3; b4 = 4'd5; a16 = 16'd300; b16 = 16'd7;
    @(negedge clk);
    check("R9 reset n4", longint'(p4), 0);
    check("R9 reset n16", longint'(p16), 0);
    rst_ni = 1'b1;

    // R1 / R8: exhaustive, registered N=4
    prev4 = 0;
    for (int ia = -8; ia < 8; ia++) begin
      for (int ib = -8; ib < 8; ib++) begin
        a4 = 4'(ia);
        b4 = 4'(ib);
        #1;
        check("R8 hold n4", longint'($signed(p4)), prev4);
        @(negedge clk);
        check("R1 n4", longint'($signed(p4)), longint'(ia * ib));
        prev4 = longint'(ia * ib);
      end
    end

    // R4 / R8: exhaustive, odd width, combinational
    for (int ia = -16; ia < 16; ia++) begin
      for (int ib = -16; ib < 16; ib++) begin
        a5 = 5'(ia);
        b5 = 5'(ib);
        #1;
        check("R4 n5", longint'($signed(p5)), longint'(ia * ib));
        @(negedge clk);
      end
    end

    // R10: exhaustive, N=8, combinational
    for (int ia = -128; ia < 128; ia++) begin
      for (int ib = -128; ib < 128; ib++) begin
        a8 = 8'(ia);
        b8 = 8'(ib);
        #1;
        check("R10 n8", longint'($signed(p8)), longint'(ia * ib));
        @(negedge clk);
      end
    end

    // R10: corner cross product at N=16
    corners = '{-32768, -1, 0, 1, 32767, -2};
    for (int i = 0; i < 6; i++)
      for (int k = 0; k < 6; k++)
        run16("R10 corner n16", corners[i], corners[k]);

    run16("R2 min*min", -32768, -32768);
    run16("R2 min*-1", -32768, -1);
    run16("R3 all-ones mult", 12345, -1);
    run16("R3 all-ones mult max", 32767, -1);
    run16("R5 min*-2", -32768, -2);
    run16("R5 alternating digits", 12345, -21846);
    run16("R5 max*min", 32767, -32768);
    run16("R6 zero multiplicand", 0, -32768);
    run16("R6 zero multiplier", 32767, 0);

    a16 = 16'hFFFD; b16 = 16'd7;
    @(negedge clk);
    check("R7 sign neg", longint'(p16[31]), 1);
    a16 = 16'hFFFD; b16 = 16'hFFF9;
    @(negedge clk);
    check("R7 sign pos", longint'(p16[31]), 0);

    for (int r = 0; r < 3000; r++)
      run16("R1 random n16", int'($signed(16'($urandom))), int'($signed(16'($urandom))));

    // R9: asynchronous clear between edges
    run16("R8 load n16", -1234, 567);
    a4 = 4'd7; b4 = 4'd7;
    @(negedge clk);
    check("R8 load n4", longint'($signed(p4)), 49);
    #2 rst_ni = 1'b0;
    #1;
    check("R9 async clear n16", longint'(p16), 0);
    check("R9 async clear n4", longint'(p4), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    summary();
  end
endmodule